// File: doc/BRIEF.md
# Deferred Condition-Flag Evaluator

This combinational unit rebuilds the four condition flags (negative, zero, carry, overflow) from a compact record of the last flag-setting operation. The flags are not held anywhere. A processor core keeps only a 4-bit operation tag and three 32-bit operand words. When a conditional instruction, a flag read or a context save needs the flags, the record is presented here. The flags come back in the same evaluation, as four single bits and as a packed word with the flags in its top nibble.

The unit reads the three operand words differently for each tag. Arithmetic tags carry the two source operands, plus the incoming carry for the carry-chained forms. The logic and multiply tags carry a ready result together with the carry and overflow values to pass through. A fault output is raised when the tag is undefined, or when an operand that must be a single bit (or a two-bit pair) has any higher bit set. While the fault output is high, every flag output is held at zero.

Top module: `nzcv_rebuild`

## Requirements
- R1: Tag 0 (copy): the flags are taken from opA, with N from bit 31, Z from bit 30, C from bit 29 and V from bit 28.
- R2: Tag 1 (add): res = opA + opB modulo 2^32. N = res[31] and Z = (res == 0). C is the unsigned carry out, which equals (res < opA). V is bit 31 of ((res ^ opA) & (res ^ opB)).
- R3: Tag 2 (subtract): res = opA - opB. C = (opA >= opB) unsigned, so C is 1 when no borrow occurs. V is bit 31 of ((opA ^ opB) & (opA ^ res)). N and Z follow res.
- R4: Tag 3 (add with carry): res = opA + opB + opC, where opC must be 0 or 1. C = (res <= opA) when opC is 1 and (res < opA) when opC is 0. N, Z and V follow res as in R2.
- R5: Tag 4 (subtract with borrow): res = opA - opB - (1 - opC), where opC must be 0 or 1. C = (opA >= opB) when opC is 1 and (opA > opB) when opC is 0. N, Z and V follow res as in R3.
- R6: Tag 5 (logic): N = opA[31] and Z = (opA == 0). C = opB and V = opC, and opB and opC must each be 0 or 1.
- R7: Tag 6 (32-bit multiply): N = opA[31] and Z = (opA == 0). C = opC[1] and V = opC[0], and opC[31:2] must be zero.
- R8: Tag 7 (64-bit multiply): opA is the low word and opB the high word. N = opB[31] and Z = ((opA | opB) == 0). C and V come from opC as in R7.
- R9: flagsPacked holds N, Z, C and V in bits 31, 30, 29 and 28, and its bits 27:0 are always zero.
- R10: badRecord is 1 for any tag from 8 to 15, and for a width violation on a defined tag (opC > 1 on tags 3 and 4; opB > 1 or opC > 1 on tag 5; opC > 3 on tags 6 and 7). When badRecord is 1, all four flags and flagsPacked are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opTag | input | 4 | Operation tag of the recorded flag-setting operation |
| opA | input | 32 | First operand word |
| opB | input | 32 | Second operand word |
| opC | input | 32 | Third operand word (old carry, or pass-through carry and overflow) |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag |
| flagsPacked | output | 32 | Flags in bits 31:28, zero below |
| badRecord | output | 1 | Undefined tag or operand width violation |

## Verification
Random operands almost never reach the hardest cases. These are subtract with borrow when the old carry is 0 and the operands are equal, so the result wraps to all ones and C must be 0, and the signed-overflow boundaries where a single carry-in tips bit 31. The bench therefore sweeps every tag against a cross product of boundary words (0, 1, 2, the signed extremes and their neighbours, all ones). It also sweeps opC through 0 to 4, which steps exactly over each width limit. Random records then fill the rest of the space.

// File: rtl/nzcv_pkg.sv
package nzcv_pkg;

  typedef enum logic [3:0] {
    TAG_COPY  = 4'd0,
    TAG_ADD   = 4'd1,
    TAG_SUB   = 4'd2,
    TAG_ADC   = 4'd3,
    TAG_SBC   = 4'd4,
    TAG_LOGIC = 4'd5,
    TAG_MUL   = 4'd6,
    TAG_MULL  = 4'd7
  } flagTag_e;

  // Strobes from the tag decoder to the flag datapath.
  typedef struct packed {
    logic selCopy;
    logic selArith;
    logic invertB;
    logic forceCarry;
    logic carryFromOld;
    logic selLogic;
    logic selMul;
    logic wideMul;
    logic fault;
  } flagCtl_t;

endpackage

// File: rtl/nzcv_tag_decode.sv
module nzcv_tag_decode
  import nzcv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        opTag,
  input  logic [DATA_W-2:0] opBUpper,
  input  logic [DATA_W-2:0] opCUpper,
  output flagCtl_t          ctl
);

  logic bWide;
  logic cWide1;
  logic cWide2;

  assign bWide  = |opBUpper;
  assign cWide1 = |opCUpper;
  assign cWide2 = |opCUpper[DATA_W-2:1];

  always_comb begin
    ctl = '0;
    unique case (opTag)
      TAG_COPY: ctl.selCopy = 1'b1;
      TAG_ADD:  ctl.selArith = 1'b1;
      TAG_SUB: begin
        ctl.selArith   = 1'b1;
        ctl.invertB    = 1'b1;
        ctl.forceCarry = 1'b1;
      end
      TAG_ADC: begin
        ctl.selArith     = 1'b1;
        ctl.carryFromOld = 1'b1;
        ctl.fault        = cWide1;
      end
      TAG_SBC: begin
        ctl.selArith     = 1'b1;
        ctl.invertB      = 1'b1;
        ctl.carryFromOld = 1'b1;
        ctl.fault        = cWide1;
      end
      TAG_LOGIC: begin
        ctl.selLogic = 1'b1;
        ctl.fault    = bWide | cWide1;
      end
      TAG_MUL: begin
        ctl.selMul = 1'b1;
        ctl.fault  = cWide2;
      end
      TAG_MULL: begin
        ctl.selMul  = 1'b1;
        ctl.wideMul = 1'b1;
        ctl.fault   = cWide2;
      end
      default: ctl.fault = 1'b1;
    endcase
  end

endmodule

// File: rtl/nzcv_flag_datapath.sv
module nzcv_flag_datapath
  import nzcv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  flagCtl_t          ctl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        opCLow,
  output logic [3:0]        nzcv
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bEff;
  logic              carryIn;
  logic [DATA_W:0]   sumFull;
  logic [DATA_W-1:0] arithRes;
  logic              arithC;
  logic              arithV;

  assign bEff     = ctl.invertB ? ~opB : opB;
  assign carryIn  = ctl.forceCarry | (ctl.carryFromOld & opCLow[0]);
  assign sumFull  = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, carryIn};
  assign arithRes = sumFull[MSB:0];
  assign arithC   = sumFull[DATA_W];
  assign arithV   = (opA[MSB] == bEff[MSB]) & (arithRes[MSB] != opA[MSB]);

  always_comb begin
    nzcv = 4'b0000;
    if (ctl.fault) begin
      nzcv = 4'b0000;
    end else if (ctl.selCopy) begin
      nzcv = opA[MSB -: 4];
    end else if (ctl.selArith) begin
      nzcv = {arithRes[MSB], arithRes == '0, arithC, arithV};
    end else if (ctl.selLogic) begin
      nzcv = {opA[MSB], opA == '0, opB[0], opCLow[0]};
    end else if (ctl.selMul) begin
      if (ctl.wideMul) nzcv = {opB[MSB], (opA | opB) == '0, opCLow};
      else             nzcv = {opA[MSB], opA == '0, opCLow};
    end
  end

endmodule

// File: rtl/nzcv_rebuild.sv
module nzcv_rebuild
  import nzcv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        opTag,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV,
  output logic [DATA_W-1:0] flagsPacked,
  output logic              badRecord
);

  localparam int PAD_W = DATA_W - 4;

  flagCtl_t   ctl;
  logic [3:0] nzcv;

  nzcv_tag_decode #(.DATA_W(DATA_W)) u_decode (
    .opTag    (opTag),
    .opBUpper (opB[DATA_W-1:1]),
    .opCUpper (opC[DATA_W-1:1]),
    .ctl      (ctl)
  );

  nzcv_flag_datapath #(.DATA_W(DATA_W)) u_datapath (
    .ctl    (ctl),
    .opA    (opA),
    .opB    (opB),
    .opCLow (opC[1:0]),
    .nzcv   (nzcv)
  );

  assign {flagN, flagZ, flagC, flagV} = nzcv;
  assign flagsPacked = {nzcv, {PAD_W{1'b0}}};
  assign badRecord   = ctl.fault;

endmodule

// File: rtl/nzcv_rebuild_checker.sv
module nzcv_rebuild_checker #(
  parameter int DATA_W = 32
) (
  input logic [3:0]        opTag,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] opC,
  input logic              flagN,
  input logic              flagZ,
  input logic              flagC,
  input logic              flagV,
  input logic [DATA_W-1:0] flagsPacked,
  input logic              badRecord
);

  localparam int MSB = DATA_W - 1;

  always_comb begin
    if (!$isunknown({opTag, opA, opB, opC})) begin
      // R10: undefined tags always fault
      a_r10_undefined_tag: assert (opTag < 4'd8 || badRecord);
      // R10: a fault clears every flag output
      a_r10_fault_clears: assert (!badRecord ||
        ({flagN, flagZ, flagC, flagV} == 4'b0 && flagsPacked == '0));
      // R1: copy tag passes opA's top nibble through to the packed word
      a_r1_copy_passes: assert (opTag != 4'd0 ||
        (flagsPacked[MSB -: 4] == opA[MSB -: 4] && flagsPacked[MSB-4:0] == '0));
      // R3: subtract carry is the unsigned no-borrow compare
      a_r3_sub_carry: assert (opTag != 4'd2 || flagC == (opA >= opB));
      // R6: logic tag passes carry and overflow through
      a_r6_logic_passes: assert (opTag != 4'd5 || badRecord ||
        (flagC == opB[0] && flagV == opC[0]));
      // R7: multiply tags pass the old carry/overflow pair through
      a_r7_mul_passes: assert (!(opTag == 4'd6 || opTag == 4'd7) || badRecord ||
        ({flagC, flagV} == opC[1:0]));
      // R2: a computed zero result can never also be negative
      a_r2_zero_not_neg: assert (opTag == 4'd0 || badRecord || !(flagZ && flagN));
    end
  end

endmodule

bind nzcv_rebuild nzcv_rebuild_checker #(.DATA_W(DATA_W)) u_checker (
  .opTag       (opTag),
  .opA         (opA),
  .opB         (opB),
  .opC         (opC),
  .flagN       (flagN),
  .flagZ       (flagZ),
  .flagC       (flagC),
  .flagV       (flagV),
  .flagsPacked (flagsPacked),
  .badRecord   (badRecord)
);

// File: tb/nzcv_rebuild_bench.sv
`timescale 1ns/1ps
module nzcv_rebuild_bench;

  logic        clk = 1'b0;
  logic [3:0]  opTag;
  logic [31:0] opA, opB, opC;
  logic        flagN, flagZ, flagC, flagV, badRecord;
  logic [31:0] flagsPacked;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nzcv_rebuild u_nzcv_rebuild (
    .opTag(opTag), .opA(opA), .opB(opB), .opC(opC),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV),
    .flagsPacked(flagsPacked), .badRecord(badRecord)
  );

  // Returns {bad, n, z, c, v}
  function automatic logic [4:0] model(input logic [3:0] t, input logic [31:0] a,
                                       input logic [31:0] b, input logic [31:0] c);
    logic [31:0] r;
    logic n, z, cf, vf;
    case (t)
      4'd0: return {1'b0, a[31:28]};
      4'd1: begin
        r = a + b; cf = r < a; vf = ((r ^ a) & (r ^ b)) >> 31;
      end
      4'd2: begin
        r = a - b; cf = a >= b; vf = ((a ^ b) & (a ^ r)) >> 31;
      end
      4'd3: begin
        if (c > 1) return 5'b10000;
        r = a + b + c; cf = c[0] ? (r <= a) : (r < a); vf = ((r ^ a) & (r ^ b)) >> 31;
      end
      4'd4: begin
        if (c > 1) return 5'b10000;
        r = a - b - (c ^ 32'd1); cf = c[0] ? (a >= b) : (a > b);
        vf = ((a ^ b) & (a ^ r)) >> 31;
      end
      4'd5: begin
        if (b > 1 || c > 1) return 5'b10000;
        r = a; cf = b[0]; vf = c[0];
      end
      4'd6: begin
        if (c > 3) return 5'b10000;
        r = a; cf = c[1]; vf = c[0];
      end
      4'd7: begin
        if (c > 3) return 5'b10000;
        n = b[31]; z = (a == 0) && (b == 0);
        return {1'b0, n, z, c[1], c[0]};
      end
      default: return 5'b10000;
    endcase
    n = r[31]; z = (r == 0);
    return {1'b0, n, z, cf, vf};
  endfunction

  function automatic string reqOf(input logic [3:0] t, input logic bad);
    if (bad) return "R10";
    case (t)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] t, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] c);
    logic [4:0] exp;
    logic [31:0] expPacked;
    @(negedge clk);
    opTag = t; opA = a; opB = b; opC = c;
    #1;
    exp = model(t, a, b, c);
    expPacked = {exp[3:0], 28'd0};
    checks++;
    if ({badRecord, flagN, flagZ, flagC, flagV} !== exp) begin
      failures++;
      $display("FAIL %s tag=%0d a=%h b=%h c=%h flags actual=%b expected=%b",
               reqOf(t, exp[4]), t, a, b, c,
               {badRecord, flagN, flagZ, flagC, flagV}, exp);
    end
    checks++;
    if (flagsPacked !== expPacked) begin
      failures++;
      // R9: packed layout N31 Z30 C29 V28, zeros below
      $display("FAIL R9 tag=%0d packed actual=%h expected=%h", t, flagsPacked, expPacked);
    end
  endtask

  logic [31:0] corner [8];

  initial begin
    opTag = 4'd0; opA = 0; opB = 0; opC = 0;
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'h0000_0002; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h8000_0000; corner[5] = 32'h8000_0001;
    corner[6] = 32'hFFFF_FFFE; corner[7] = 32'hFFFF_FFFF;

    // Initial state: all-zero copy record gives clear flags (R1)
    apply(4'd0, 32'h0, 32'h0, 32'h0);
    // Directed: R5 equal operands with old carry 0 wraps, C must be 0
    apply(4'd4, 32'h1234_5678, 32'h1234_5678, 32'd0);
    // Directed: R4 carry-in exactly closes the gap
    apply(4'd3, 32'hFFFF_FFFF, 32'h0, 32'd1);
    // Directed: R8 low word alone nonzero keeps Z clear
    apply(4'd7, 32'h1, 32'h0, 32'd2);
    // Directed: R10 width limit crossed by one bit
    apply(4'd6, 32'h0, 32'h0, 32'd4);
    apply(4'd5, 32'h0, 32'd2, 32'd0);

    for (int t = 0; t < 16; t++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int k = 0; k < 5; k++)
            apply(t[3:0], corner[i], corner[j], k);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rc;
      rc = $urandom;
      apply(4'($urandom % 16), $urandom, (n % 2) ? $urandom : ($urandom % 2),
            (n % 3 == 0) ? rc : (rc % 4));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired before the sweep completed");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule